// File: doc/BRIEF.md
# Dual-Condition Key Interrupt Generator

This block produces the active-low interrupt that tells a host processor about key activity. Two triggers feed it. The first is a timer that counts debounce-cycle strobes after the most recent key event. The second compares the number of events held in the event queue against a programmed depth. Either trigger can be switched off by its own field of an 8-bit configuration byte. When both are on, the interrupt asserts as soon as either one fires.

After it asserts, the interrupt stays latched until its clear condition occurs. A separate mode bit picks that condition: either any read of the queue, or the queue becoming empty. When the whole configuration byte is zero, both triggers are off and the pin becomes a plain general-purpose output that follows a data bit. Every input is a level or a single-cycle strobe that the block samples on each clock. No data stream crosses the boundary, so there is no valid/ready handshake, and the block never stalls or pushes back on its sources.

Top module: `kint_gen`

## Requirements
- R1: After reset with a nonzero configuration byte, `irq_n` is high (deasserted). The interrupt is active-low.
- R2: With time code T = `cfg_byte[4:0]` in 1..31, `irq_n` goes low in the cycle after the T-th `deb_tick` that follows a `key_evt`. It does not go low on any earlier tick.
- R3: A new `key_evt` restarts the debounce-cycle count from zero.
- R4: A time code of 0 disables the time trigger. Key events and ticks then never assert the interrupt.
- R5: With depth code D = `cfg_byte[7:5]` in 1..7, the interrupt asserts in the cycle after `fifo_count` >= 2*D. A depth code of 0 disables this trigger.
- R6: When both triggers are enabled, the interrupt asserts on whichever condition is met first.
- R7: Once asserted, the interrupt stays low after its triggering condition goes away, until the selected clear condition occurs.
- R8: With `clr_on_read` = 1, a `fifo_rd` pulse deasserts the interrupt in the next cycle. A clear takes priority over a trigger in the same cycle. A trigger that still holds asserts the interrupt again one cycle later.
- R9: With `clr_on_read` = 0, `fifo_rd` has no effect. The interrupt clears only in the cycle after `fifo_count` is 0.
- R10: When `cfg_byte` is 0x00, `irq_n` equals `gpo_bit` combinationally. With any nonzero byte, `gpo_bit` has no effect on `irq_n`.
- R11: When `key_evt` and `deb_tick` arrive in the same cycle, the count restarts and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_byte | input | 8 | Interrupt configuration: [7:5] depth code, [4:0] time code |
| clr_on_read | input | 1 | 1: any read clears; 0: clear when queue empty |
| deb_tick | input | 1 | One-cycle strobe at the end of each debounce cycle |
| key_evt | input | 1 | One-cycle strobe when a key event is queued |
| fifo_count | input | 5 | Number of events currently stored (0..16) |
| fifo_rd | input | 1 | One-cycle strobe when the host reads the queue |
| gpo_bit | input | 1 | Output level used when the pin is a general-purpose output |
| irq_n | output | 1 | Active-low interrupt, or the general-purpose output level |

## Verification
The bench sweeps every time code and checks that the interrupt appears exactly on the programmed tick. A counter that is off by one would assert one tick early or late. The bench sweeps every depth code with a rising queue count. A threshold that is wrong, or a comparison that is strict where it should be inclusive, would move the assertion point. Same-cycle collisions are also covered. A key event together with a tick catches a design that counts that tick. A read while the depth still holds catches a design that lets the trigger mask the clear. Finally, the bench confirms that the read strobe is ignored in empty-clear mode, and that the data bit reaches the pin only when the configuration byte is zero.

// File: rtl/kint_pkg.sv
package kint_pkg;
  localparam int TIME_BITS  = 5;
  localparam int DEPTH_BITS = 3;
  localparam int CFG_W      = TIME_BITS + DEPTH_BITS;

  typedef enum logic {
    CLR_ON_EMPTY = 1'b0,
    CLR_ON_READ  = 1'b1
  } clr_mode_e;

  typedef struct packed {
    logic [DEPTH_BITS-1:0] dcode;
    logic [TIME_BITS-1:0]  tcode;
  } kint_cfg_t;
endpackage

// File: rtl/kint_timer.sv
module kint_timer
  import kint_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TIME_BITS-1:0] tcode,
  input  logic                 key_evt,
  input  logic                 deb_tick,
  output logic                 time_hit
);
  logic                 armed_q;
  logic [TIME_BITS-1:0] cnt_q;
  logic [TIME_BITS-1:0] cnt_nxt;
  logic                 enabled;

  assign enabled  = (tcode != '0);
  assign cnt_nxt  = cnt_q + 1'b1;
  assign time_hit = armed_q && deb_tick && !key_evt && (cnt_nxt == tcode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (key_evt) begin
      armed_q <= enabled;
      cnt_q   <= '0;
    end else if (!enabled) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q && deb_tick) begin
      if (time_hit) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_nxt;
      end
    end
  end

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_evt && enabled) |=> (armed_q && cnt_q == '0));

  // R2
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_hit |=> !armed_q);
endmodule

// File: rtl/kint_depth.sv
module kint_depth
  import kint_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic [DEPTH_BITS-1:0] dcode,
  input  logic [CNT_W-1:0]      fifo_count,
  output logic                  depth_hit
);
  localparam int CMP_W = (CNT_W > DEPTH_BITS) ? CNT_W + 1 : DEPTH_BITS + 2;

  logic [CMP_W-1:0] thresh;
  logic [CMP_W-1:0] level;

  assign thresh    = CMP_W'({dcode, 1'b0});
  assign level     = CMP_W'(fifo_count);
  assign depth_hit = (dcode != '0) && (level >= thresh);
endmodule

// File: rtl/kint_latch.sv
module kint_latch
  import kint_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      time_hit,
  input  logic      depth_hit,
  input  clr_mode_e mode,
  input  logic      fifo_rd,
  input  logic      fifo_empty,
  input  logic      gpo_mode,
  output logic      irq_q
);
  logic set_any;
  logic clr;

  assign set_any = time_hit | depth_hit;
  assign clr     = gpo_mode | ((mode == CLR_ON_READ) ? fifo_rd : fifo_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (clr)     irq_q <= 1'b0;
    else if (set_any) irq_q <= 1'b1;
  end

  // R6
  set_on_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_any && !clr) |=> irq_q);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CLR_ON_READ && fifo_rd) |=> !irq_q);

  // R9
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && mode == CLR_ON_EMPTY && !fifo_empty && !gpo_mode) |=> irq_q);
endmodule

// File: rtl/kint_gen.sv
module kint_gen
  import kint_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_byte,
  input  logic             clr_on_read,
  input  logic             deb_tick,
  input  logic             key_evt,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             fifo_rd,
  input  logic             gpo_bit,
  output logic             irq_n
);
  kint_cfg_t cfg;
  logic      gpo_mode;
  logic      time_hit;
  logic      depth_hit;
  logic      irq_q;
  clr_mode_e mode;

  assign cfg      = kint_cfg_t'(cfg_byte);
  assign gpo_mode = (cfg_byte == '0);
  assign mode     = clr_on_read ? CLR_ON_READ : CLR_ON_EMPTY;

  kint_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tcode    (cfg.tcode),
    .key_evt  (key_evt),
    .deb_tick (deb_tick),
    .time_hit (time_hit)
  );

  kint_depth #(.FIFO_DEPTH(FIFO_DEPTH)) u_depth (
    .dcode      (cfg.dcode),
    .fifo_count (fifo_count),
    .depth_hit  (depth_hit)
  );

  kint_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .time_hit   (time_hit),
    .depth_hit  (depth_hit),
    .mode       (mode),
    .fifo_rd    (fifo_rd),
    .fifo_empty (fifo_count == '0),
    .gpo_mode   (gpo_mode),
    .irq_q      (irq_q)
  );

  assign irq_n = gpo_mode ? gpo_bit : ~irq_q;

  // R10
  gpo_idle_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpo_mode |=> (!irq_q || !gpo_mode));
endmodule

// File: tb/kint_gen_bench.sv
module kint_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_byte = 8'h01;
  logic       clr_on_read = 1'b0;
  logic       deb_tick = 1'b0;
  logic       key_evt = 1'b0;
  logic [4:0] fifo_count = '0;
  logic       fifo_rd = 1'b0;
  logic       gpo_bit = 1'b0;
  logic       irq_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  kint_gen u_kint_gen (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .clr_on_read(clr_on_read),
    .deb_tick(deb_tick), .key_evt(key_evt), .fifo_count(fifo_count),
    .fifo_rd(fifo_rd), .gpo_bit(gpo_bit), .irq_n(irq_n)
  );

  task automatic step();
    @(posedge clk);
    #1;
    key_evt  = 1'b0;
    deb_tick = 1'b0;
    fifo_rd  = 1'b0;
    @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s irq_n=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cleanup();
    fifo_count = '0;
    fifo_rd = 1'b1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_n, 1'b1, "R1 reset state");

    // R2: every time code, depth trigger off, empty-clear mode
    for (int t = 1; t < 32; t++) begin
      cfg_byte = 8'(t);
      clr_on_read = 1'b0;
      fifo_count = 5'd1;
      key_evt = 1'b1; step();
      for (int k = 1; k <= t; k++) begin
        deb_tick = 1'b1; step();
        check(irq_n, (k < t) ? 1'b1 : 1'b0, "R2 tick count");
      end
      repeat (3) step();
      check(irq_n, 1'b0, "R7 latched after time trigger");
      cleanup();
      check(irq_n, 1'b1, "R9 clear on empty");
    end

    // R5 / R8: every depth code, read-clear mode, rising count
    for (int d = 0; d < 8; d++) begin
      cfg_byte = 8'(d << 5);
      if (d == 0) cfg_byte = 8'h00 | 8'h00;
      clr_on_read = 1'b1;
      if (d == 0) begin
        cfg_byte = 8'h00;
      end
      if (d != 0) begin
        for (int c = 0; c <= 16; c++) begin
          fifo_count = 5'(c); step();
          check(irq_n, (c >= 2 * d) ? 1'b0 : 1'b1, "R5 depth threshold");
        end
        fifo_rd = 1'b1; step();
        check(irq_n, 1'b1, "R8 read clears");
        step();
        check(irq_n, 1'b0, "R8 depth reasserts");
        cleanup();
      end
    end

    // R5: depth code 0 with time code 0 is GPO mode; use time code 31 with no key
    cfg_byte = 8'h1F; clr_on_read = 1'b1;
    for (int c = 0; c <= 16; c++) begin
      fifo_count = 5'(c); step();
    end
    check(irq_n, 1'b1, "R5 depth code 0 disabled");
    cleanup();

    // R4: time code 0, depth 14 not reached
    cfg_byte = 8'hE0; clr_on_read = 1'b0; fifo_count = 5'd1;
    key_evt = 1'b1; step();
    for (int k = 0; k < 40; k++) begin deb_tick = 1'b1; step(); end
    check(irq_n, 1'b1, "R4 time code 0 disabled");
    cleanup();

    // R3: restart on new key event
    cfg_byte = 8'h04; clr_on_read = 1'b0; fifo_count = 5'd2;
    key_evt = 1'b1; step();
    for (int k = 0; k < 3; k++) begin deb_tick = 1'b1; step(); end
    key_evt = 1'b1; step();
    for (int k = 0; k < 3; k++) begin deb_tick = 1'b1; step(); end
    check(irq_n, 1'b1, "R3 restart no early fire");
    deb_tick = 1'b1; step();
    check(irq_n, 1'b0, "R3 fire after restart");
    cleanup();

    // R11: key event and tick in the same cycle
    cfg_byte = 8'h02; fifo_count = 5'd1;
    key_evt = 1'b1; step();
    deb_tick = 1'b1; step();
    key_evt = 1'b1; deb_tick = 1'b1; step();
    check(irq_n, 1'b1, "R11 collision tick not counted");
    deb_tick = 1'b1; step();
    check(irq_n, 1'b1, "R11 first tick after restart");
    deb_tick = 1'b1; step();
    check(irq_n, 1'b0, "R11 second tick fires");
    cleanup();

    // R6: both enabled, depth first
    cfg_byte = 8'h23; clr_on_read = 1'b0; fifo_count = 5'd1;
    key_evt = 1'b1; step();
    fifo_count = 5'd2; step();
    check(irq_n, 1'b0, "R6 depth first");
    cleanup();
    // R6: both enabled, time first
    cfg_byte = 8'hE3; fifo_count = 5'd1;
    key_evt = 1'b1; step();
    for (int k = 0; k < 3; k++) begin deb_tick = 1'b1; step(); end
    check(irq_n, 1'b0, "R6 time first");
    cleanup();

    // R7 / R9: depth trigger goes away, reads ignored in empty mode
    cfg_byte = 8'h40; clr_on_read = 1'b0; fifo_count = 5'd4; step();
    check(irq_n, 1'b0, "R5 depth 4 reached");
    fifo_count = 5'd1;
    fifo_rd = 1'b1; step();
    check(irq_n, 1'b0, "R9 read ignored in empty mode");
    repeat (4) step();
    check(irq_n, 1'b0, "R7 latched after depth drop");
    fifo_count = 5'd0; step();
    check(irq_n, 1'b1, "R9 clear when empty");

    // R10: GPO mode and its absence
    cfg_byte = 8'h00; fifo_count = 5'd0;
    gpo_bit = 1'b0; #1;
    check(irq_n, 1'b0, "R10 gpo low");
    gpo_bit = 1'b1; #1;
    check(irq_n, 1'b1, "R10 gpo high");
    cfg_byte = 8'h05; gpo_bit = 1'b0; step();
    check(irq_n, 1'b1, "R10 gpo ignored when configured");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule